// File: doc/BRIEF.md
# Pipelined Binary to Packed-BCD Converter

This block turns an unsigned binary word into packed decimal digits using the shift-and-add-3 method. It is laid out as a pipeline. A capture register takes the input word, and one register stage follows for each shift step that can need a digit correction. A new word can therefore enter on every clock. With the default 8-bit input, the output is 12 bits wide. It holds the hundreds, tens and units digits from the most to the least significant nibble.

Correction cells sit only at the digit positions and shift steps where a digit can actually reach five or more. The place of each cell is worked out during elaboration from the input width. At the default width this gives seven cells. There are five on the units digit, from the third shift onward, and two on the tens digit, after the sixth and seventh shifts. The hundreds digit has none, and no correction follows the final shift.

A valid strobe travels alongside the data. A synchronous reset clears only the valid bits, so the data registers stay free of reset logic.

Top module: `bcd_pipe_conv`

## Requirements
- R1: When `out_valid` is high, `out_bcd[11:8]`, `out_bcd[7:4]` and `out_bcd[3:0]` hold the hundreds, tens and units decimal digits of the input word, each as a 4-bit binary value.
- R2: A word presented with `in_valid` high in clock cycle n appears on `out_bcd` with `out_valid` high in cycle n+6. `out_valid` is low in the cycles between, unless other words occupy them.
- R3: Words presented on consecutive cycles come out on consecutive cycles, in order, one conversion per clock.
- R4: `rst` is synchronous and active high, and it clears every valid bit in the pipeline. Words in flight when `rst` is sampled high never come out. Neither does a word presented in the same cycle as `rst`. `out_valid` stays low for the first 6 cycles after reset.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low 6 cycles later, so gaps in the input stream are kept.
- R6: When `out_valid` is high, `out_bcd[0]` equals bit 0 of the converted input, and `out_bcd[11:10]` is 0. The hundreds digit is never above 2.
- R7: Every digit on `out_bcd` is at most 9 when `out_valid` is high.
- R8: A correction cell adds 3 to a digit above 4 (5..9 become 8..12) and passes 0..4 unchanged. Cells are placed only where a digit can reach 5. Every digit position without a cell stays below 5 at that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Marks `in_bin` as a word to convert |
| in_bin | input | 8 | Unsigned binary input word |
| out_valid | output | 1 | Marks `out_bcd` as a finished result |
| out_bcd | output | 12 | Packed digits: hundreds, tens, units |

## Verification
On every clock, the assertions check three things. Every digit entering a stage is a legal decimal value. Every uncorrected position stays below five, which shows the pruning is safe. The top digit never exceeds its arithmetic maximum, and no result leaves the pipeline during the six cycles after reset. Only the bench scenarios can show the rest. These are the exact digit values for all 256 inputs, the six-cycle latency, back-to-back throughput, gaps in the stream, and words dropped by a reset while in flight.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  function automatic longint pow10(input int d);
    longint p;
    p = 1;
    for (int i = 0; i < d; i++) p = p * 10;
    return p;
  endfunction

  // number of decimal digits needed for the largest IN_W-bit value
  function automatic int bcd_digits(input int in_w);
    longint v;
    int n;
    v = (64'd1 << in_w) - 1;
    n = 0;
    while (v != 0) begin
      n++;
      v = v / 10;
    end
    return n;
  endfunction

  // after `step` shifts the converted prefix is at most 2^step-1;
  // a digit can reach 5 only if that prefix can reach 5*10^digit
  function automatic bit cell_needed(input int digit, input int step);
    return ((64'd1 << step) - 1) >= 5 * pow10(digit);
  endfunction

  function automatic int first_step(input int in_w);
    for (int s = 1; s < in_w; s++)
      if (cell_needed(0, s)) return s;
    return in_w;
  endfunction

  function automatic int top_digit_max(input int in_w);
    return int'(((64'd1 << in_w) - 1) / pow10(bcd_digits(in_w) - 1));
  endfunction

endpackage

// File: rtl/bcd_add3_cell.sv
module bcd_add3_cell (
  input  logic [3:0] d_i,
  output logic [3:0] d_o
);

  logic over4;

  always_comb begin
    over4 = d_i[3] | (d_i[2] & (d_i[1] | d_i[0]));
    d_o   = over4 ? d_i + 4'd3 : d_i;
  end

endmodule

// File: rtl/bcd_capture_stage.sv
module bcd_capture_stage #(
  parameter int IN_W  = 8,
  parameter int NDIG  = 3,
  parameter int PRESH = 3,
  localparam int W    = NDIG * 4 + IN_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [IN_W-1:0] bin_i,
  output logic            valid_o,
  output logic [W-1:0]    data_o
);

  logic [W-1:0] widened;

  // shifts before the first possible correction are plain wiring
  assign widened = {{(NDIG * 4){1'b0}}, bin_i};

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= valid_i;
    data_o <= widened << PRESH;
  end

endmodule

// File: rtl/bcd_dabble_stage.sv
module bcd_dabble_stage #(
  parameter int IN_W = 8,
  parameter int NDIG = 3,
  parameter int STEP = 3,
  localparam int W   = NDIG * 4 + IN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  logic [W-1:0] adj;
  logic         unused_msb;

  assign adj[IN_W-1:0] = data_i[IN_W-1:0];
  assign unused_msb    = adj[W-1];

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    localparam int LO = IN_W + 4 * d;

    if (bcd_conv_pkg::cell_needed(d, STEP)) begin : g_cell
      bcd_add3_cell u_cell (
        .d_i (data_i[LO +: 4]),
        .d_o (adj[LO +: 4])
      );
    end else begin : g_pass
      assign adj[LO +: 4] = data_i[LO +: 4];

      // R8
      prune_safe_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> (data_i[LO +: 4] < 4'd5));
    end

    // R7
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      valid_i |-> (data_i[LO +: 4] <= 4'd9));
  end

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= valid_i;
    data_o <= {adj[W-2:0], 1'b0};
  end

endmodule

// File: rtl/bcd_pipe_conv.sv
module bcd_pipe_conv #(
  parameter int IN_W   = 8,
  localparam int NDIG  = bcd_conv_pkg::bcd_digits(IN_W),
  localparam int OUT_W = NDIG * 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_bin,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_bcd
);

  localparam int FIRST  = bcd_conv_pkg::first_step(IN_W);
  localparam int NSTAGE = IN_W - FIRST;
  localparam int LAT    = NSTAGE + 1;
  localparam int W      = OUT_W + IN_W;
  localparam int CW     = $clog2(LAT + 1);
  localparam logic [3:0] TOP_MAX = 4'(bcd_conv_pkg::top_digit_max(IN_W));

  logic [W-1:0] data  [0:NSTAGE];
  logic         valid [0:NSTAGE];
  logic         unused_tail;

  bcd_capture_stage #(
    .IN_W  (IN_W),
    .NDIG  (NDIG),
    .PRESH (FIRST)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .bin_i   (in_bin),
    .valid_o (valid[0]),
    .data_o  (data[0])
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    bcd_dabble_stage #(
      .IN_W (IN_W),
      .NDIG (NDIG),
      .STEP (FIRST + k)
    ) u_stg (
      .clk     (clk),
      .rst     (rst),
      .valid_i (valid[k]),
      .data_i  (data[k]),
      .valid_o (valid[k+1]),
      .data_o  (data[k+1])
    );
  end

  assign out_valid   = valid[NSTAGE];
  assign out_bcd     = data[NSTAGE][W-1 -: OUT_W];
  assign unused_tail = ^data[NSTAGE][IN_W-1:0];

  // cycles since reset, saturating at the pipeline latency
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                       since_rst <= '0;
    else if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  // R4
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(LAT)) |-> !out_valid);

  // R6
  top_digit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bcd[OUT_W-1 -: 4] <= TOP_MAX));

endmodule

// File: tb/sim_bcd_pipe_conv.sv
module sim_bcd_pipe_conv;

  localparam int LAT   = 6;
  localparam int CLK_P = 20;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_bin = 8'd0;
  logic        out_valid;
  logic [11:0] out_bcd;

  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc      = 0;
  bit   armed    = 1'b0;
  string tag     = "R4";

  logic        exp_v [0:DEPTH-1];
  logic [11:0] exp_d [0:DEPTH-1];

  always #(CLK_P / 2) clk = ~clk;

  bcd_pipe_conv #(.IN_W(8)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bin    (in_bin),
    .out_valid (out_valid),
    .out_bcd   (out_bcd)
  );

  function automatic logic [11:0] bcd_ref(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check_outputs();
    n_checks++;
    if (out_valid !== exp_v[cyc]) begin
      n_fails++;
      $display("FAIL %s cycle %0d: out_valid=%b expected %b", tag, cyc, out_valid, exp_v[cyc]);
    end
    if (exp_v[cyc] === 1'b1) begin
      // R1: digit values
      n_checks++;
      if (out_bcd !== exp_d[cyc]) begin
        n_fails++;
        $display("FAIL R1 cycle %0d: out_bcd=%h expected %h", cyc, out_bcd, exp_d[cyc]);
      end
      // R6: fixed bits
      n_checks++;
      if (out_bcd[0] !== exp_d[cyc][0] || out_bcd[11:10] !== 2'b00) begin
        n_fails++;
        $display("FAIL R6 cycle %0d: out_bcd=%h expected bit0=%b top=00", cyc, out_bcd, exp_d[cyc][0]);
      end
      // R7: legal digits
      n_checks++;
      if (out_bcd[11:8] > 4'd9 || out_bcd[7:4] > 4'd9 || out_bcd[3:0] > 4'd9) begin
        n_fails++;
        $display("FAIL R7 cycle %0d: out_bcd=%h expected all digits <= 9", cyc, out_bcd);
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [7:0] b);
    if (armed) check_outputs();
    rst      = r;
    in_valid = v;
    in_bin   = b;
    if (r) begin
      for (int k = 1; k <= LAT; k++) exp_v[cyc + k] = 1'b0;
      armed = 1'b1;
    end else if (v) begin
      exp_v[cyc + LAT] = 1'b1;
      exp_d[cyc + LAT] = bcd_ref(int'(b));
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      exp_v[i] = 1'b0;
      exp_d[i] = '0;
    end
    @(negedge clk);

    // R4: reset state, inputs offered during reset never emerge
    tag = "R4";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'd99);
    idle(8);

    // R1 R3: exhaustive back-to-back sweep
    tag = "R3";
    for (int v = 0; v < 256; v++) step(1'b0, 1'b1, 8'(v));
    idle(8);

    // R5: descending sweep with a gap before every third word
    tag = "R5";
    for (int v = 255; v >= 0; v--) begin
      if (v % 3 == 0) step(1'b0, 1'b0, 8'(v));
      step(1'b0, 1'b1, 8'(v));
    end
    idle(8);

    // R2: isolated word, exact latency
    tag = "R2";
    step(1'b0, 1'b1, 8'd199);
    idle(8);

    // R4: reset while words are in flight
    tag = "R4";
    for (int v = 10; v < 14; v++) step(1'b0, 1'b1, 8'(v));
    step(1'b1, 1'b1, 8'd50);
    idle(10);

    // R2: pipeline usable after the mid-stream reset
    tag = "R2";
    step(1'b0, 1'b1, 8'd255);
    step(1'b0, 1'b1, 8'd128);
    idle(8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule